// File: doc/BRIEF.md
# Tagged-Pointer Future Check and Touch Unit

This block screens instruction operands for pointers that carry the future type tag and resolves such futures on request. Every word keeps its type in its low bits. Any word with a 1 in bit 0 is a future. For a strict compute operation the unit examines both source operands. For a memory operation it examines both address operands. If any examined operand is a future, the unit raises a trap in the same cycle and reports which operand caused it. Plain data moves are never checked.

The touch side takes a future pointer from the trap handler. It clears the tag bits and reads the word at a fixed byte offset from that base, called the value slot, together with the slot's full/empty flag. There are three possible results. A full slot holding an ordinary value ends the touch with that value, which the pipeline writes over the register. An empty slot ends the touch with a request to switch the thread out. A full slot that holds another future is followed, up to a bounded number of extra reads, and the touch is abandoned with an overrun pulse once that bound is used up.

Top module: `fut_touch_unit`

## Requirements
- R1: With `chk_valid` high and `chk_class` = 2'b01 (compute), `trap` is high in the same cycle if and only if bit 0 of `chk_op_a` or of `chk_op_b` is 1. `trap_idx` is 0 when `chk_op_a` is a future and 1 when only `chk_op_b` is.
- R2: With `chk_valid` high and `chk_class` = 2'b10 (memory), the two operands are address operands, and trap and index follow the same rule as R1.
- R3: With `chk_class` = 2'b11 (non-strict move) or 2'b00 (no operation), or with `chk_valid` low, `trap` stays low whatever the operands are.
- R4: The type codes in the low bits are 00 for fixnum, 010 for other, 110 for cons and 101 for future. Of these, only the future code causes a trap.
- R5: Each read of a touch raises `mem_rd_en` for one cycle with `mem_rd_addr` = (pointer with its low TAG_W bits cleared) + SLOT_OFS. The first read comes in the cycle after the request is accepted. `mem_rd_data` and `mem_rd_full` must be valid in the cycle after `mem_rd_en`.
- R6: When the slot is full and its word has bit 0 = 0, `touch_done` pulses for one cycle, with `touch_value` equal to that word, in the second cycle after the read.
- R7: When the slot is empty, `touch_switch` pulses for one cycle, with the same timing as R6, and `touch_done` stays low.
- R8: When the slot is full and holds a future, the next read goes through that word. If the bound of MAX_CHAIN follow-on reads has been reached, `touch_overrun` pulses instead. Each touch ends with exactly one of `touch_done`, `touch_switch` and `touch_overrun`.
- R9: `touch_busy` is high from the cycle after acceptance until the outcome pulse. A `touch_req` that arrives while busy is ignored, and the reads keep following the original pointer.
- R10: After reset, and whenever the unit is idle, `touch_busy`, `mem_rd_en` and all three outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Operand check request this cycle |
| chk_class | input | 2 | 00 none, 01 compute, 10 memory, 11 non-strict move |
| chk_op_a | input | DATA_W | First source or address operand |
| chk_op_b | input | DATA_W | Second source or address operand |
| trap | output | 1 | Future found in a checked operand |
| trap_idx | output | 1 | Index of the lowest offending operand |
| touch_req | input | 1 | Start resolving `touch_ptr` |
| touch_ptr | input | DATA_W | Future pointer to resolve |
| mem_rd_en | output | 1 | Value-slot read strobe |
| mem_rd_addr | output | DATA_W | Value-slot byte address |
| mem_rd_data | input | DATA_W | Slot word, one cycle after the strobe |
| mem_rd_full | input | 1 | Slot full/empty flag, one cycle after the strobe |
| touch_busy | output | 1 | Touch in progress |
| touch_done | output | 1 | Resolved value available |
| touch_value | output | DATA_W | Resolved value |
| touch_switch | output | 1 | Slot empty, switch thread out |
| touch_overrun | output | 1 | Chain bound exhausted |

## Verification
The embedded properties check the following on every cycle: a move or idle class never traps, a trap always points at an operand whose bit 0 is set, at most one outcome pulse is high at a time, an accepted request is followed by a read, an empty slot leads to a switch, and a delivered value is never a future. Only the bench's scenarios can show the real slot addresses along a chain, the two-cycle spacing per hop, the exact point where the overrun bound takes over from a further read, and that a request arriving while busy leaves the walk unchanged. Those scenarios are compared against a behavioural walk of the bench's own memory.

// File: rtl/fut_pkg.sv
package fut_pkg;
    typedef enum logic [1:0] {
        CLS_NONE    = 2'b00,
        CLS_COMPUTE = 2'b01,
        CLS_MEMORY  = 2'b10,
        CLS_MOVE    = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        TS_IDLE = 2'b00,
        TS_READ = 2'b01,
        TS_WAIT = 2'b10
    } touch_st_e;
endpackage

// File: rtl/fut_tag_check.sv
module fut_tag_check #(
    parameter int DATA_W  = 32,
    parameter int NUM_OPS = 2,
    localparam int IDX_W  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
    input  logic                            enable,
    input  logic [NUM_OPS-1:0][DATA_W-1:0]  ops,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx
);
    logic [NUM_OPS-1:0] is_fut;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lsb
        assign is_fut[g] = ops[g][0];
    end

    always_comb begin
        hit     = enable && (|is_fut);
        hit_idx = '0;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (is_fut[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fut_touch_fsm.sv
module fut_touch_fsm
    import fut_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 3,
    parameter int SLOT_OFS  = 4,
    parameter int MAX_CHAIN = 3,
    localparam int HOP_W    = $clog2(MAX_CHAIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] ptr,
    output logic              rd_en,
    output logic [DATA_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_full,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] value,
    output logic              sw,
    output logic              ovr
);
    localparam logic [DATA_W-1:0] TAG_MASK = DATA_W'((1 << TAG_W) - 1);

    typedef struct packed {
        touch_st_e         st;
        logic [DATA_W-1:0] ptr;
        logic [HOP_W-1:0]  hops;
        logic              done;
        logic              sw;
        logic              ovr;
        logic [DATA_W-1:0] value;
    } touch_s;

    touch_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.sw   = 1'b0;
        st_d.ovr  = 1'b0;
        case (st_q.st)
            TS_IDLE: begin
                if (req) begin
                    st_d.st   = TS_READ;
                    st_d.ptr  = ptr;
                    st_d.hops = '0;
                end
            end
            TS_READ: st_d.st = TS_WAIT;
            TS_WAIT: begin
                if (!rd_full) begin
                    st_d.sw = 1'b1;
                    st_d.st = TS_IDLE;
                end else if (!rd_data[0]) begin
                    st_d.done  = 1'b1;
                    st_d.value = rd_data;
                    st_d.st    = TS_IDLE;
                end else if (st_q.hops == HOP_W'(MAX_CHAIN)) begin
                    st_d.ovr = 1'b1;
                    st_d.st  = TS_IDLE;
                end else begin
                    st_d.ptr  = rd_data;
                    st_d.hops = st_q.hops + HOP_W'(1);
                    st_d.st   = TS_READ;
                end
            end
            default: st_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: TS_IDLE, ptr: '0, hops: '0, done: 1'b0,
                      sw: 1'b0, ovr: 1'b0, value: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en   = (st_q.st == TS_READ);
    assign rd_addr = (st_q.ptr & ~TAG_MASK) + DATA_W'(SLOT_OFS);
    assign busy    = (st_q.st != TS_IDLE);
    assign done    = st_q.done;
    assign value   = st_q.value;
    assign sw      = st_q.sw;
    assign ovr     = st_q.ovr;

    // R8: a touch never reports two outcomes at once
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, sw, ovr}));

    // R5: an accepted request issues a read next cycle
    p_read_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> rd_en);

    // R7: an empty slot seen in the wait state yields a switch
    p_switch_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == TS_WAIT && !rd_full) |=> sw);

    // R6: a delivered value is never itself a future
    p_done_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !value[0]);

    // R9: the walked pointer does not move while a read is pending
    p_ptr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(st_q.ptr));
endmodule

// File: rtl/fut_touch_unit.sv
module fut_touch_unit
    import fut_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 3,
    parameter int SLOT_OFS  = 4,
    parameter int MAX_CHAIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [1:0]        chk_class,
    input  logic [DATA_W-1:0] chk_op_a,
    input  logic [DATA_W-1:0] chk_op_b,
    output logic              trap,
    output logic              trap_idx,
    input  logic              touch_req,
    input  logic [DATA_W-1:0] touch_ptr,
    output logic              mem_rd_en,
    output logic [DATA_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_full,
    output logic              touch_busy,
    output logic              touch_done,
    output logic [DATA_W-1:0] touch_value,
    output logic              touch_switch,
    output logic              touch_overrun
);
    localparam int NUM_OPS = 2;

    op_class_e                      cls;
    logic                           strict_chk;
    logic [NUM_OPS-1:0][DATA_W-1:0] ops;

    assign cls        = op_class_e'(chk_class);
    assign strict_chk = chk_valid && (cls == CLS_COMPUTE || cls == CLS_MEMORY);
    assign ops        = {chk_op_b, chk_op_a};

    fut_tag_check #(
        .DATA_W (DATA_W),
        .NUM_OPS(NUM_OPS)
    ) u_check (
        .enable (strict_chk),
        .ops    (ops),
        .hit    (trap),
        .hit_idx(trap_idx)
    );

    fut_touch_fsm #(
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W),
        .SLOT_OFS (SLOT_OFS),
        .MAX_CHAIN(MAX_CHAIN)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (touch_req),
        .ptr    (touch_ptr),
        .rd_en  (mem_rd_en),
        .rd_addr(mem_rd_addr),
        .rd_data(mem_rd_data),
        .rd_full(mem_rd_full),
        .busy   (touch_busy),
        .done   (touch_done),
        .value  (touch_value),
        .sw     (touch_switch),
        .ovr    (touch_overrun)
    );

    // R3: non-strict or idle classes never trap
    p_move_no_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_valid || chk_class == 2'b11 || chk_class == 2'b00) |-> !trap);

    // R1: the reported operand really carries the future tag
    p_trap_points_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (trap_idx ? chk_op_b[0] : chk_op_a[0]));

    // R2: a trap only comes from a strict class
    p_trap_strict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (chk_valid && (chk_class == 2'b01 || chk_class == 2'b10)));

    // R10: no reads while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_busy |-> !mem_rd_en);
endmodule

// File: tb/fut_touch_unit_bench.sv
`timescale 1ns/1ps
module fut_touch_unit_bench;
    localparam int MAXC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_class = 2'b00;
    logic [31:0] chk_op_a = '0, chk_op_b = '0;
    logic        trap, trap_idx;
    logic        touch_req = 1'b0;
    logic [31:0] touch_ptr = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_full = 1'b0;
    logic        touch_busy, touch_done, touch_switch, touch_overrun;
    logic [31:0] touch_value;

    int checks = 0, failures = 0;
    bit in_touch = 1'b1;
    bit finished = 1'b0;

    logic [31:0] mem_w [0:63];
    bit          mem_f [0:63];

    always #2 clk = ~clk;

    fut_touch_unit #(.MAX_CHAIN(MAXC)) u_fut_touch_unit (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_class(chk_class),
        .chk_op_a(chk_op_a), .chk_op_b(chk_op_b), .trap(trap), .trap_idx(trap_idx),
        .touch_req(touch_req), .touch_ptr(touch_ptr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_rd_full(mem_rd_full),
        .touch_busy(touch_busy), .touch_done(touch_done), .touch_value(touch_value),
        .touch_switch(touch_switch), .touch_overrun(touch_overrun));

    always @(posedge clk) begin
        mem_rd_data <= mem_w[mem_rd_addr[7:2]];
        mem_rd_full <= mem_f[mem_rd_addr[7:2]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock reference for the operand checker
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit strict, etrap;
            string rq;
            strict = chk_valid && (chk_class == 2'b01 || chk_class == 2'b10);
            etrap  = strict && (chk_op_a[0] || chk_op_b[0]);
            rq = (!strict) ? "R3" : (chk_class == 2'b01 ? "R1" : "R2");
            chk(trap == etrap, rq, "trap", 32'(trap), 32'(etrap));
            if (etrap)
                chk(trap_idx == !chk_op_a[0], rq, "trap_idx", 32'(trap_idx), 32'(!chk_op_a[0]));
        end
    end

    // per-clock idle reference
    always @(negedge clk) begin
        #2;
        if (rst_n && !in_touch) begin
            chk(!touch_busy && !mem_rd_en, "R10", "idle busy/rd",
                {30'd0, touch_busy, mem_rd_en}, 32'd0);
            chk(!touch_done && !touch_switch && !touch_overrun, "R10", "idle outcome",
                {29'd0, touch_done, touch_switch, touch_overrun}, 32'd0);
        end
    end

    // outcome: 0 done, 1 switch, 2 overrun
    task automatic run_touch(input logic [31:0] ptr, input bit noise, input logic [31:0] alt,
                             input string rq);
        logic [31:0] addrs [0:7];
        int n, outc, hops;
        logic [31:0] p, val, a;
        p = ptr; n = 0; hops = 0; outc = 0; val = '0;
        forever begin
            a = {p[31:3], 3'b000} + 32'd4;
            addrs[n] = a; n++;
            if (!mem_f[a[7:2]]) begin outc = 1; break; end
            if (!mem_w[a[7:2]][0]) begin outc = 0; val = mem_w[a[7:2]]; break; end
            if (hops == MAXC) begin outc = 2; break; end
            p = mem_w[a[7:2]]; hops++;
        end
        @(negedge clk);
        in_touch = 1'b1; touch_req = 1'b1; touch_ptr = ptr;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (noise) touch_ptr = alt; else touch_req = 1'b0;
            #1;
            chk(mem_rd_en && touch_busy, "R5", "read strobe/busy",
                {30'd0, mem_rd_en, touch_busy}, 32'd3);
            chk(mem_rd_addr == addrs[k], (noise ? "R9" : "R5"), "slot address",
                mem_rd_addr, addrs[k]);
            @(negedge clk); #1;
            chk(!mem_rd_en && touch_busy, "R9", "wait phase",
                {30'd0, mem_rd_en, touch_busy}, 32'd1);
            chk(!touch_done && !touch_switch && !touch_overrun, "R8", "early outcome",
                {29'd0, touch_done, touch_switch, touch_overrun}, 32'd0);
        end
        @(negedge clk);
        touch_req = 1'b0;
        #1;
        chk({touch_done, touch_switch, touch_overrun} == 3'(3'b100 >> outc), rq, "outcome",
            {29'd0, touch_done, touch_switch, touch_overrun}, 32'(3'b100 >> outc));
        chk(!touch_busy, "R9", "busy at outcome", 32'(touch_busy), 32'd0);
        if (outc == 0) chk(touch_value == val, "R6", "value", touch_value, val);
        @(negedge clk);
        in_touch = 1'b0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] tags [0:3];
        tags[0] = 32'h100; tags[1] = 32'h102; tags[2] = 32'h106; tags[3] = 32'h105;
        for (int i = 0; i < 64; i++) begin mem_w[i] = '0; mem_f[i] = 1'b0; end
        mem_w[5'h05] = 32'h0000_1230; mem_f[5'h05] = 1'b1; // slot of 0x15
        mem_f[6'h09] = 1'b0;                               // slot of 0x25: empty
        mem_w[6'h0D] = 32'h45; mem_f[6'h0D] = 1'b1;        // 0x35 -> 0x45
        mem_w[6'h11] = 32'h56; mem_f[6'h11] = 1'b1;        // 0x45 -> cons 0x56
        mem_w[6'h19] = 32'h65; mem_f[6'h19] = 1'b1;        // 0x65 loops to itself
        mem_w[6'h1D] = 32'h85; mem_f[6'h1D] = 1'b1;        // 0x75 -> 0x85
        mem_f[6'h21] = 1'b0;                               // slot of 0x85: empty

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!touch_busy && !mem_rd_en && !touch_done, "R10", "reset state",
            {29'd0, touch_busy, mem_rd_en, touch_done}, 32'd0);
        in_touch = 1'b0;

        // R1 R2 R3 R4: every class against every tag pair
        for (int c = 0; c < 4; c++)
            for (int x = 0; x < 4; x++)
                for (int y = 0; y < 4; y++) begin
                    @(negedge clk);
                    chk_valid = 1'b1; chk_class = 2'(c);
                    chk_op_a = tags[x]; chk_op_b = tags[y];
                end
        @(negedge clk);
        chk_valid = 1'b0; chk_class = 2'b01; chk_op_a = 32'h105; chk_op_b = 32'h105; // R3
        @(negedge clk);
        chk_class = 2'b00; chk_op_a = '0; chk_op_b = '0;

        run_touch(32'h15, 1'b0, 32'h0, "R6");
        run_touch(32'h25, 1'b0, 32'h0, "R7");
        run_touch(32'h35, 1'b0, 32'h0, "R8");
        run_touch(32'h65, 1'b0, 32'h0, "R8");
        run_touch(32'h75, 1'b0, 32'h0, "R7");
        run_touch(32'h15, 1'b1, 32'h25, "R9");
        repeat (3) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end
endmodule